// File: doc/BRIEF.md
# Set-Associative Data Address Translation Buffer

This block sits in front of a data cache on the load/store path and turns a 64-bit effective address into a real address. When the relocate input is high, the page number is looked up in a small two-way array of 4 KiB page entries. When the relocate input is low, the address passes through unchanged. The lookup is registered, so each request gets one response cycle later. The response carries a hit/miss flag, the real address, a cache-inhibit flag and the way that matched. It also carries the real page number held in each way of the indexed set. A following cache can therefore compare its own tags against both candidates in parallel and use the way select only at the final multiplexer.

There is no table walker. Software fills entries, flushes the whole array or drops one page through a management command with two 64-bit operands: a control word and an entry value. The entry value uses a radix-style page table entry layout. A miss raises no fault. The miss flag tells the requester to skip the access.

Top module: `dtlb_xlate`

## Requirements
- R1: A lookup presented with `lk_valid_i` high gives `rsp_valid_o` high on the following cycle, and only then. Bits 11:0 of `rsp_ra_o` always equal bits 11:0 of the effective address. On a translated hit, bits 55:12 hold the stored real page number and bits 63:56 are zero.
- R2: With `relocate_i` low, the response has `rsp_hit_o` high, `rsp_miss_o` low, way select 0, and `rsp_ra_o` equal to the full effective address.
- R3: With `relocate_i` low, `rsp_cinh_o` is 1 exactly when address bits 31:28 equal 4'hC. With `relocate_i` high, it is the stored entry attribute on a hit and 0 on a miss, whatever the address.
- R4: The array has 2 ways of 64 sets. The set is chosen by effective page number bits 5:0 (address bits 17:12). A hit needs a valid entry whose stored tag equals page number bits 51:6.
- R5: A translated lookup with no matching valid entry gives `rsp_hit_o`=0, `rsp_miss_o`=1, `rsp_cinh_o`=0 and `rsp_ra_o` holding only the page offset (upper bits zero).
- R6: A command whose control word has bit 10 or bit 11 set invalidates every entry in both ways.
- R7: A command with control bits 11:9 = 3'b001 writes an entry for the page in control bits 63:12. The real page number comes from entry-value bits 55:12, and the cache-inhibit attribute comes from entry-value bit 5.
- R8: A command with control bits 11:9 = 3'b000 invalidates only the entry whose tag matches the page in control bits 63:12, in whichever way holds it. Other entries of that set stay valid.
- R9: A write whose page already has a valid entry in the set overwrites that way and never makes a second copy.
- R10: A write to a page not present goes to the least-recently-used way of its set. A translated hit marks the hit way as most recently used, and a write marks the written way as most recently used. After reset, way 0 is the first victim of every set.
- R11: `rsp_way_o` gives the hitting way (0 or 1). `rsp_rpn0_o` and `rsp_rpn1_o` give the real page numbers stored in way 0 and way 1 of the looked-up set.
- R12: A lookup and a command in the same cycle: the lookup sees the array contents from before the command.
- R13: Reset empties the array, and `rsp_valid_o` is low until the first lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_ea_i | input | 64 | Effective address to translate |
| relocate_i | input | 1 | 1 = translate, 0 = real mode |
| cmd_valid_i | input | 1 | Management command strobe |
| cmd_ctl_i | input | 64 | Control word: page number in 63:12, operation in 11:9 |
| cmd_pte_i | input | 64 | Entry value for writes (radix-style layout) |
| rsp_valid_o | output | 1 | Response valid, one cycle after the lookup |
| rsp_hit_o | output | 1 | Translation available |
| rsp_miss_o | output | 1 | Translation missing; the access must be skipped |
| rsp_ra_o | output | 64 | Real address |
| rsp_cinh_o | output | 1 | Access is cache-inhibited |
| rsp_way_o | output | 1 | Hitting way |
| rsp_rpn0_o | output | 44 | Real page number held in way 0 of the set |
| rsp_rpn1_o | output | 44 | Real page number held in way 1 of the set |

## Verification
The hardest state to reach from the ports is a set that is full and whose replacement order has been reversed by a hit. Reaching it needs two writes of distinct pages that share page-number bits 5:0, then a lookup hit on the older one, then a third same-set write. That write must then evict the younger entry. The bench builds this sequence from a fresh reset so the replacement bit is known. It separately drives a write and a lookup of the same page in one cycle to expose the read-before-write ordering.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  localparam int unsigned NUM_WAYS = 2;

  typedef enum logic [1:0] {
    TC_IDLE,
    TC_FLUSH,
    TC_DROP,
    TC_FILL
  } tlb_cmd_e;
endpackage

// File: rtl/dtlb_cmd_decode.sv
module dtlb_cmd_decode
  import dtlb_pkg::*;
(
  input  logic       cmd_valid_i,
  input  logic [2:0] op_bits_i,   // control word bits 11:9
  output tlb_cmd_e   kind_o
);
  always_comb begin
    kind_o = TC_IDLE;
    if (cmd_valid_i) begin
      if (op_bits_i[2] || op_bits_i[1]) kind_o = TC_FLUSH;
      else if (op_bits_i[0])            kind_o = TC_FILL;
      else                              kind_o = TC_DROP;
    end
  end
endmodule

// File: rtl/dtlb_way.sv
module dtlb_way #(
  parameter int unsigned SET_BITS = 6,
  parameter int unsigned TAG_W    = 46,
  parameter int unsigned RPN_W    = 44
) (
  input  logic                clk_i,
  input  logic                rst_n,
  input  logic [SET_BITS-1:0] rd_set_i,
  input  logic [TAG_W-1:0]    rd_tag_i,
  output logic                rd_hit_o,
  output logic [RPN_W-1:0]    rd_rpn_o,
  output logic                rd_ci_o,
  input  logic [SET_BITS-1:0] cmd_set_i,
  input  logic [TAG_W-1:0]    cmd_tag_i,
  output logic                cmd_match_o,
  input  logic                flush_i,
  input  logic                drop_i,
  input  logic                wr_en_i,
  input  logic [RPN_W-1:0]    wr_rpn_i,
  input  logic                wr_ci_i
);
  localparam int unsigned SETS = 1 << SET_BITS;

  logic [SETS-1:0]  valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [RPN_W-1:0] rpn_q [SETS];
  logic [SETS-1:0]  ci_q;

  assign rd_hit_o    = valid_q[rd_set_i] && (tag_q[rd_set_i] == rd_tag_i);
  assign rd_rpn_o    = rpn_q[rd_set_i];
  assign rd_ci_o     = ci_q[rd_set_i];
  assign cmd_match_o = valid_q[cmd_set_i] && (tag_q[cmd_set_i] == cmd_tag_i);

  always_comb begin
    valid_d = valid_q;
    if (flush_i) begin
      valid_d = '0;
    end else begin
      if (drop_i && cmd_match_o) valid_d[cmd_set_i] = 1'b0;
      if (wr_en_i)               valid_d[cmd_set_i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[cmd_set_i] <= cmd_tag_i;
      rpn_q[cmd_set_i] <= wr_rpn_i;
      ci_q[cmd_set_i]  <= wr_ci_i;
    end
  end

  // R6
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    flush_i |=> (valid_q == '0));

  // R8
  drop_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (drop_i && cmd_match_o) |=> !valid_q[$past(cmd_set_i)]);
endmodule

// File: rtl/dtlb_victim.sv
module dtlb_victim #(
  parameter int unsigned SET_BITS = 6
) (
  input  logic                clk_i,
  input  logic                rst_n,
  input  logic                touch_i,
  input  logic [SET_BITS-1:0] touch_set_i,
  input  logic                touch_way_i,
  input  logic                fill_i,
  input  logic [SET_BITS-1:0] fill_set_i,
  input  logic                fill_way_i,
  output logic                victim_o   // LRU way of fill_set_i
);
  localparam int unsigned SETS = 1 << SET_BITS;

  logic [SETS-1:0] lru_q, lru_d;

  assign victim_o = lru_q[fill_set_i];

  always_comb begin
    lru_d = lru_q;
    if (touch_i) lru_d[touch_set_i] = ~touch_way_i;
    if (fill_i)  lru_d[fill_set_i]  = ~fill_way_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else        lru_q <= lru_d;
  end

  // R10
  fill_recent_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    fill_i |=> (lru_q[$past(fill_set_i)] != $past(fill_way_i)));
endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
  import dtlb_pkg::*;
#(
  parameter int unsigned EA_W       = 64,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned SET_BITS   = 6,
  parameter int unsigned RPN_W      = 44,
  parameter int unsigned CI_BIT     = 5
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             lk_valid_i,
  input  logic [63:0]      lk_ea_i,
  input  logic             relocate_i,
  input  logic             cmd_valid_i,
  input  logic [63:0]      cmd_ctl_i,
  input  logic [63:0]      cmd_pte_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic             rsp_miss_o,
  output logic [63:0]      rsp_ra_o,
  output logic             rsp_cinh_o,
  output logic             rsp_way_o,
  output logic [43:0]      rsp_rpn0_o,
  output logic [43:0]      rsp_rpn1_o
);
  localparam int unsigned EPN_W = EA_W - PAGE_SHIFT;
  localparam int unsigned TAG_W = EPN_W - SET_BITS;
  localparam int unsigned PAD_W = EA_W - PAGE_SHIFT - RPN_W;

  // lookup address split
  logic [EPN_W-1:0]    lk_epn;
  logic [SET_BITS-1:0] lk_set;
  logic [TAG_W-1:0]    lk_tag;
  assign lk_epn = lk_ea_i[EA_W-1:PAGE_SHIFT];
  assign lk_set = lk_epn[SET_BITS-1:0];
  assign lk_tag = lk_epn[EPN_W-1:SET_BITS];

  // command address split
  logic [EPN_W-1:0]    cmd_epn;
  logic [SET_BITS-1:0] cmd_set;
  logic [TAG_W-1:0]    cmd_tag;
  assign cmd_epn = cmd_ctl_i[EA_W-1:PAGE_SHIFT];
  assign cmd_set = cmd_epn[SET_BITS-1:0];
  assign cmd_tag = cmd_epn[EPN_W-1:SET_BITS];

  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{cmd_ctl_i[8:0], cmd_pte_i[63:PAGE_SHIFT+RPN_W],
                             cmd_pte_i[PAGE_SHIFT-1:CI_BIT+1], cmd_pte_i[CI_BIT-1:0]};

  tlb_cmd_e cmd_kind;
  dtlb_cmd_decode u_dec (
    .cmd_valid_i (cmd_valid_i),
    .op_bits_i   (cmd_ctl_i[11:9]),
    .kind_o      (cmd_kind)
  );

  logic do_flush, do_drop, do_fill;
  assign do_flush = (cmd_kind == TC_FLUSH);
  assign do_drop  = (cmd_kind == TC_DROP);
  assign do_fill  = (cmd_kind == TC_FILL);

  logic [NUM_WAYS-1:0] way_hit, way_ci, way_match;
  logic [RPN_W-1:0]    way_rpn [NUM_WAYS];
  logic                victim, fill_way;

  // an existing copy of the page wins over the LRU victim
  always_comb begin
    if (way_match[1])      fill_way = 1'b1;
    else if (way_match[0]) fill_way = 1'b0;
    else                   fill_way = victim;
  end

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    dtlb_way #(
      .SET_BITS (SET_BITS),
      .TAG_W    (TAG_W),
      .RPN_W    (RPN_W)
    ) u_way (
      .clk_i       (clk_i),
      .rst_n       (rst_n),
      .rd_set_i    (lk_set),
      .rd_tag_i    (lk_tag),
      .rd_hit_o    (way_hit[g]),
      .rd_rpn_o    (way_rpn[g]),
      .rd_ci_o     (way_ci[g]),
      .cmd_set_i   (cmd_set),
      .cmd_tag_i   (cmd_tag),
      .cmd_match_o (way_match[g]),
      .flush_i     (do_flush),
      .drop_i      (do_drop),
      .wr_en_i     (do_fill && (fill_way == g[0])),
      .wr_rpn_i    (cmd_pte_i[PAGE_SHIFT+RPN_W-1:PAGE_SHIFT]),
      .wr_ci_i     (cmd_pte_i[CI_BIT])
    );
  end

  logic any_hit, hit_way;
  assign any_hit = |way_hit;
  assign hit_way = way_hit[1];

  dtlb_victim #(.SET_BITS(SET_BITS)) u_lru (
    .clk_i       (clk_i),
    .rst_n       (rst_n),
    .touch_i     (lk_valid_i && relocate_i && any_hit),
    .touch_set_i (lk_set),
    .touch_way_i (hit_way),
    .fill_i      (do_fill),
    .fill_set_i  (cmd_set),
    .fill_way_i  (fill_way),
    .victim_o    (victim)
  );

  // response next-state
  logic [EA_W-1:0]  ra_d, ra_q;
  logic             hit_d, hit_q, ci_d, ci_q, way_d, way_q, valid_q;
  logic [RPN_W-1:0] rpn0_q, rpn1_q;
  logic [RPN_W-1:0] sel_rpn;
  assign sel_rpn = hit_way ? way_rpn[1] : way_rpn[0];

  always_comb begin
    if (!relocate_i) begin
      ra_d  = lk_ea_i;
      hit_d = 1'b1;
      ci_d  = (lk_ea_i[31:28] == 4'hC);
      way_d = 1'b0;
    end else begin
      hit_d = any_hit;
      way_d = hit_way;
      ci_d  = any_hit && (hit_way ? way_ci[1] : way_ci[0]);
      if (any_hit) ra_d = {{PAD_W{1'b0}}, sel_rpn, lk_ea_i[PAGE_SHIFT-1:0]};
      else         ra_d = {{(EA_W-PAGE_SHIFT){1'b0}}, lk_ea_i[PAGE_SHIFT-1:0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= lk_valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (lk_valid_i) begin
      ra_q   <= ra_d;
      hit_q  <= hit_d;
      ci_q   <= ci_d;
      way_q  <= way_d;
      rpn0_q <= way_rpn[0];
      rpn1_q <= way_rpn[1];
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_hit_o   = valid_q && hit_q;
  assign rsp_miss_o  = valid_q && !hit_q;
  assign rsp_ra_o    = ra_q;
  assign rsp_cinh_o  = valid_q && ci_q;
  assign rsp_way_o   = way_q;
  assign rsp_rpn0_o  = rpn0_q;
  assign rsp_rpn1_o  = rpn1_q;

  // R1
  offset_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    lk_valid_i |=> (rsp_valid_o && rsp_ra_o[PAGE_SHIFT-1:0] == $past(lk_ea_i[PAGE_SHIFT-1:0])));

  // R13
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !lk_valid_i |=> !rsp_valid_o);

  // R2
  real_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (lk_valid_i && !relocate_i) |=> (rsp_hit_o && rsp_ra_o == $past(lk_ea_i)));

  // R5
  miss_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    rsp_miss_o |-> (!rsp_cinh_o && rsp_ra_o[EA_W-1:PAGE_SHIFT] == '0));

  // R9
  way_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(way_hit));
endmodule

// File: tb/dtlb_xlate_test.sv
module dtlb_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [63:0] lk_ea = '0;
  logic        relocate = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [63:0] cmd_ctl = '0;
  logic [63:0] cmd_pte = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_cinh, rsp_way;
  logic [63:0] rsp_ra;
  logic [43:0] rsp_rpn0, rsp_rpn1;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dtlb_xlate uut (
    .clk_i (clk), .rst_n (rst_n),
    .lk_valid_i (lk_valid), .lk_ea_i (lk_ea), .relocate_i (relocate),
    .cmd_valid_i (cmd_valid), .cmd_ctl_i (cmd_ctl), .cmd_pte_i (cmd_pte),
    .rsp_valid_o (rsp_valid), .rsp_hit_o (rsp_hit), .rsp_miss_o (rsp_miss),
    .rsp_ra_o (rsp_ra), .rsp_cinh_o (rsp_cinh), .rsp_way_o (rsp_way),
    .rsp_rpn0_o (rsp_rpn0), .rsp_rpn1_o (rsp_rpn1)
  );

  typedef struct packed {
    logic        rel;
    logic [63:0] ea;
    logic        hit;
    logic        way;
    logic        ci;
    logic [63:0] ra;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{rel:1'b1, ea:64'h0000_0000_1234_5123, hit:1'b1, way:1'b0, ci:1'b0, ra:64'h0000_0000_00AB_C123},
    '{rel:1'b1, ea:64'h0000_0000_1238_5FFF, hit:1'b1, way:1'b1, ci:1'b1, ra:64'h0000_0000_0077_7FFF},
    '{rel:1'b1, ea:64'hABCD_E000_0004_0000, hit:1'b1, way:1'b0, ci:1'b0, ra:64'h0000_0012_3456_7000},
    '{rel:1'b1, ea:64'h0000_0000_1234_6456, hit:1'b0, way:1'b0, ci:1'b0, ra:64'h0000_0000_0000_0456},
    '{rel:1'b1, ea:64'h0000_0000_1230_5010, hit:1'b0, way:1'b0, ci:1'b0, ra:64'h0000_0000_0000_0010},
    '{rel:1'b0, ea:64'h0000_0000_C000_1000, hit:1'b1, way:1'b0, ci:1'b1, ra:64'h0000_0000_C000_1000},
    '{rel:1'b0, ea:64'h0000_0000_B000_0000, hit:1'b1, way:1'b0, ci:1'b0, ra:64'h0000_0000_B000_0000},
    '{rel:1'b0, ea:64'hFFFF_FFFF_1234_5123, hit:1'b1, way:1'b0, ci:1'b0, ra:64'hFFFF_FFFF_1234_5123},
    '{rel:1'b1, ea:64'h0000_0000_C000_0000, hit:1'b0, way:1'b0, ci:1'b0, ra:64'h0000_0000_0000_0000},
    '{rel:1'b0, ea:64'h1234_0000_CFFF_FFFF, hit:1'b1, way:1'b0, ci:1'b1, ra:64'h1234_0000_CFFF_FFFF}
  };

  localparam logic [51:0] PG_A = 52'h00000_00012345;
  localparam logic [51:0] PG_B = 52'h00000_00012385;
  localparam logic [51:0] PG_C = 52'hABCDE_00000040;
  localparam logic [51:0] PG_D = 52'h00000_000123C5;
  localparam logic [51:0] PG_E = 52'h00000_00055507;

  function automatic logic [63:0] mk_pte(logic [43:0] rpn, logic ci);
    mk_pte = {8'h00, rpn, 12'h000} | {58'h0, ci, 5'h00};
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_cmd(logic [63:0] ctl, logic [63:0] pte);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_ctl = ctl; cmd_pte = pte;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic fill(logic [51:0] pg, logic [43:0] rpn, logic ci);
    do_cmd({pg, 12'h200}, mk_pte(rpn, ci));
  endtask

  // drive a lookup; outputs are sampled at the next falling edge
  task automatic look(logic rel, logic [63:0] ea);
    @(negedge clk);
    lk_valid = 1'b1; relocate = rel; lk_ea = ea;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_hit(string tag, logic [51:0] pg, logic [43:0] rpn, logic way);
    look(1'b1, {pg, 12'h3A5});
    chk(tag, {62'h0, rsp_hit, rsp_way}, {62'h0, 1'b1, way});
    chk(tag, rsp_ra, {8'h00, rpn, 12'h3A5});
  endtask

  task automatic expect_miss(string tag, logic [51:0] pg);
    look(1'b1, {pg, 12'h3A5});
    chk(tag, {62'h0, rsp_hit, rsp_miss}, {62'h0, 1'b0, 1'b1});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R13 reset state
    chk("R13 valid after reset", {63'h0, rsp_valid}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 valid idle", {63'h0, rsp_valid}, 64'h0);
    expect_miss("R13 empty after reset", PG_A);

    // R7 fills; R10 first victims are way 0
    fill(PG_A, 44'h000_0000_0ABC, 1'b0);
    fill(PG_B, 44'h000_0000_0777, 1'b1);
    fill(PG_C, 44'h000_0123_4567, 1'b0);

    // vector table: R1 R2 R3 R4 R5 R11
    for (int i = 0; i < NV; i++) begin
      look(VECS[i].rel, VECS[i].ea);
      chk($sformatf("R1 valid vec%0d", i), {63'h0, rsp_valid}, 64'h1);
      chk($sformatf("R4 R5 hit vec%0d", i), {62'h0, rsp_hit, rsp_miss}, {62'h0, VECS[i].hit, !VECS[i].hit});
      chk($sformatf("R1 R2 ra vec%0d", i), rsp_ra, VECS[i].ra);
      chk($sformatf("R3 cinh vec%0d", i), {63'h0, rsp_cinh}, {63'h0, VECS[i].ci});
      if (VECS[i].hit)
        chk($sformatf("R11 way vec%0d", i), {63'h0, rsp_way}, {63'h0, VECS[i].way});
    end

    // R11 candidate page numbers of set 5
    look(1'b1, {PG_A, 12'h000});
    chk("R11 rpn way0", {20'h0, rsp_rpn0}, 64'hABC);
    chk("R11 rpn way1", {20'h0, rsp_rpn1}, 64'h777);

    // R9 refill of a present page reuses its way
    fill(PG_B, 44'h000_0000_0999, 1'b0);
    expect_hit("R9 overwrite B", PG_B, 44'h000_0000_0999, 1'b1);
    expect_hit("R9 A intact", PG_A, 44'h000_0000_0ABC, 1'b0);

    // R8 drop one page only
    do_cmd({PG_A, 12'h000}, 64'h0);
    expect_miss("R8 A dropped", PG_A);
    expect_hit("R8 B kept", PG_B, 44'h000_0000_0999, 1'b1);

    // R6 flush via bit 11
    do_cmd(64'h800, 64'h0);
    expect_miss("R6 flush11 B", PG_B);
    expect_miss("R6 flush11 C", PG_C);

    // R10 replacement order with a hit refresh
    do_reset();
    fill(PG_A, 44'h000_0000_0AAA, 1'b0);
    fill(PG_B, 44'h000_0000_0BBB, 1'b0);
    expect_hit("R10 A way0", PG_A, 44'h000_0000_0AAA, 1'b0);
    fill(PG_D, 44'h000_0000_0DDD, 1'b0);
    expect_miss("R10 B evicted", PG_B);
    expect_hit("R10 A kept", PG_A, 44'h000_0000_0AAA, 1'b0);
    expect_hit("R10 D in way1", PG_D, 44'h000_0000_0DDD, 1'b1);

    // R6 flush via bit 10 (bit 9 also set: flush wins)
    do_cmd(64'h600, 64'h0);
    expect_miss("R6 flush10 A", PG_A);
    expect_miss("R6 flush10 D", PG_D);

    // R12 same-cycle write and lookup
    @(negedge clk);
    cmd_valid = 1'b1; cmd_ctl = {PG_E, 12'h200}; cmd_pte = mk_pte(44'h000_0000_0EEE, 1'b1);
    lk_valid = 1'b1; relocate = 1'b1; lk_ea = {PG_E, 12'h001};
    @(negedge clk);
    cmd_valid = 1'b0; lk_valid = 1'b0;
    chk("R12 old contents seen", {63'h0, rsp_miss}, 64'h1);
    look(1'b1, {PG_E, 12'h001});
    chk("R12 later hit", rsp_ra, 64'h0000_0000_00EE_E001);
    chk("R3 R7 entry cinh", {63'h0, rsp_cinh}, 64'h1);

    // R13 no response without a request
    @(negedge clk);
    chk("R13 no request", {63'h0, rsp_valid}, 64'h0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule